// File: doc/BRIEF.md
# Block Memory Copy Sequencer

This block moves a run of bytes from one region of a byte-addressed memory to another. It works through a synchronous memory port with a read strobe and a write strobe. Each element costs one read and then one write. A host loads a 16-bit source address, a 16-bit destination address and a 16-bit element count, and picks a stepping mode and whether the copy repeats. It then pulses `start_i`. While the copy runs, `busy_o` stays high. When the last element has been written and its step time has run out, `done_o` pulses for one clock, and the final address and count values are on the result outputs.

Five stepping modes are provided:
- Both addresses count up.
- Both addresses count down.
- The source counts down while the destination counts up.
- Pattern mode: the read address takes its top bits from the frozen source register and its three low bits from the destination, so an 8-byte tile is replicated across the destination.
- Wrapped-byte mode: only the low byte of the source and only the high byte of the destination advance.

A repeating copy keeps going until the count reaches zero. A single-step copy moves exactly one element.

Step timing is fixed. A step that will be followed by another lasts 21 clocks. A final or single step lasts 16 clocks. This keeps the throughput of the block predictable for the surrounding system.

Top module: `blkcopy_seq`

## Requirements
- R1: Mode code 0 (up): each element reads address `src`, writes that byte to `dst`, then `src` and `dst` each increase by 1 and `cnt` decreases by 1, all modulo 2^16.
- R2: Mode code 1 (down): each element reads `src`, writes it to `dst`, then `src`, `dst` and `cnt` each decrease by 1 modulo 2^16.
- R3: Mode code 2 (mixed): each element reads `src`, writes it to `dst`, then `src` decreases by 1, `dst` increases by 1 and `cnt` decreases by 1.
- R4: Mode code 3 (pattern): the read address is `{src[15:3], dst[2:0]}`; `src` never changes during the copy, `dst` increases by 1 and `cnt` decreases by 1 per element.
- R5: Mode code 4 (wrapped byte): the byte at `src` is written to `dst`. Then `src[7:0]` increases by 1 wrapping within 8 bits, and `dst[15:8]` increases by 1 wrapping within 8 bits. `src[15:8]`, `dst[7:0]` and `cnt` are unchanged. This mode always moves exactly one element, whatever `repeat_i` says.
- R6: With `repeat_i`=1 the copy continues until the decremented count is zero. With `repeat_i`=0 exactly one element is moved, whatever the count.
- R7: A repeating copy started with a count of 0 moves 65536 elements and ends with count 0.
- R8: Timing and data path:
  - Each step raises `rd_en_o` in its first clock and `wr_en_o` in its second clock.
  - `wr_data_o` carries the value on `rd_data_i` in that second clock; the memory returns read data one clock after the strobe.
  - A step followed by another lasts 21 clocks, and the last step lasts 16.
  - `busy_o` is high for exactly the sum of the step lengths.
- R9: `done_o` is high for exactly one clock, in the first clock after `busy_o` falls. In that clock `src_o`, `dst_o` and `cnt_o` hold the final values.
- R10: `start_i` and all set-up inputs are ignored while `busy_o` is high.
- R11: After reset, `busy_o`, `done_o`, `rd_en_o` and `wr_en_o` are low and the result outputs are zero.
- R12: Mode codes 5 to 7 behave exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a copy (taken only when idle) |
| mode_i | input | 3 | Stepping mode code |
| repeat_i | input | 1 | 1 = repeat until count is zero, 0 = one element |
| src_i | input | 16 | Initial source address |
| dst_i | input | 16 | Initial destination address |
| cnt_i | input | 16 | Initial element count |
| rd_en_o | output | 1 | Memory read strobe |
| rd_addr_o | output | 16 | Memory read address |
| rd_data_i | input | 8 | Read data, valid one clock after the strobe |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | 16 | Memory write address |
| wr_data_o | output | 8 | Memory write data |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-clock completion pulse |
| src_o | output | 16 | Current/final source address |
| dst_o | output | 16 | Current/final destination address |
| cnt_o | output | 16 | Current/final count |

## Verification
The bench sweeps every mode code with single and repeated runs, using start addresses that sit on byte and word boundaries, and follows each step clock by clock against an arithmetic model.

The following corner cases are targeted, with the failure each one would expose:
- Byte wraps at the boundaries: a design that let the wrapped-byte increments carry into the neighbouring byte would show a wrong address after `xxFF`.
- Pattern mode: a design that moved the source would show a drifting read address.
- Continue/finish decision: a design that decided it from the count after decrementing, rather than before, would stretch or cut `busy_o` by five clocks per run.
- Zero count with repeat: a design that tested the count for zero before decrementing would stop after no elements instead of 65536.
- Start pulse mid-copy: a design that honoured it would overwrite the registers.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;

    localparam int unsigned AW = 16;        // address and count width
    localparam int unsigned DW = 8;         // element width
    localparam int unsigned HALF = AW / 2;  // byte lane for wrapped stepping

    typedef enum logic [2:0] {
        MODE_UP   = 3'd0,
        MODE_DOWN = 3'd1,
        MODE_MIX  = 3'd2,
        MODE_PAT  = 3'd3,
        MODE_WRAP = 3'd4
    } step_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        seq_state_e      st;
        step_mode_e      mode;
        logic            rep;
        logic            cont;
        logic            done;
        logic [AW-1:0]   src;
        logic [AW-1:0]   dst;
        logic [AW-1:0]   cnt;
    } seq_regs_t;

    // reserved codes fall back to the ascending mode
    function automatic step_mode_e decode_mode(input logic [2:0] code);
        case (code)
            3'd1:    return MODE_DOWN;
            3'd2:    return MODE_MIX;
            3'd3:    return MODE_PAT;
            3'd4:    return MODE_WRAP;
            default: return MODE_UP;
        endcase
    endfunction

endpackage

// File: rtl/blkcopy_addr_step.sv
module blkcopy_addr_step
    import blkcopy_pkg::*;
#(
    parameter int unsigned PAT_BITS = 3
) (
    input  step_mode_e      mode_i,
    input  logic [AW-1:0]   src_i,
    input  logic [AW-1:0]   dst_i,
    input  logic [AW-1:0]   cnt_i,
    output logic [AW-1:0]   rd_addr_o,
    output logic [AW-1:0]   src_nx_o,
    output logic [AW-1:0]   dst_nx_o,
    output logic [AW-1:0]   cnt_nx_o,
    output logic            last_o
);

    logic [AW-1:0] pat_addr;
    logic [AW-1:0] one;

    assign one = AW'(1);

    generate
        if (PAT_BITS > 0) begin : g_pat
            assign pat_addr = {src_i[AW-1:PAT_BITS], dst_i[PAT_BITS-1:0]};
        end else begin : g_nopat
            assign pat_addr = src_i;
        end
    endgenerate

    always_comb begin
        rd_addr_o = src_i;
        src_nx_o  = src_i + one;
        dst_nx_o  = dst_i + one;
        cnt_nx_o  = cnt_i - one;
        case (mode_i)
            MODE_DOWN: begin
                src_nx_o = src_i - one;
                dst_nx_o = dst_i - one;
            end
            MODE_MIX: begin
                src_nx_o = src_i - one;
            end
            MODE_PAT: begin
                rd_addr_o = pat_addr;
                src_nx_o  = src_i;
            end
            MODE_WRAP: begin
                src_nx_o = {src_i[AW-1:HALF], src_i[HALF-1:0] + HALF'(1)};
                dst_nx_o = {dst_i[AW-1:HALF] + HALF'(1), dst_i[HALF-1:0]};
                cnt_nx_o = cnt_i;
            end
            default: ;
        endcase
        last_o = (cnt_nx_o == '0);
    end

endmodule

// File: rtl/blkcopy_step_timer.sv
module blkcopy_step_timer #(
    parameter int unsigned COST_CONT = 21,
    parameter int unsigned COST_LAST = 16,
    localparam int unsigned COST_MAX = (COST_CONT > COST_LAST) ? COST_CONT : COST_LAST,
    localparam int unsigned PH_W     = $clog2(COST_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic            cont_i,
    output logic [PH_W-1:0] phase_o,
    output logic            end_o
);

    logic [PH_W-1:0] ph_d, ph_q;
    logic [PH_W-1:0] cost;

    assign cost    = cont_i ? PH_W'(COST_CONT) : PH_W'(COST_LAST);
    assign phase_o = ph_q;

    always_comb begin
        end_o = run_i && (ph_q == cost - PH_W'(1));
        if (!run_i || end_o) ph_d = '0;
        else                 ph_d = ph_q + PH_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (ph_q < cost));  // R8

endmodule

// File: rtl/blkcopy_seq.sv
module blkcopy_seq
    import blkcopy_pkg::*;
#(
    parameter int unsigned STEP_CONT = 21,
    parameter int unsigned STEP_LAST = 16,
    parameter int unsigned PAT_BITS  = 3,
    localparam int unsigned COST_MAX = (STEP_CONT > STEP_LAST) ? STEP_CONT : STEP_LAST,
    localparam int unsigned PH_W     = $clog2(COST_MAX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [2:0]     mode_i,
    input  logic           repeat_i,
    input  logic [15:0]    src_i,
    input  logic [15:0]    dst_i,
    input  logic [15:0]    cnt_i,
    output logic           rd_en_o,
    output logic [15:0]    rd_addr_o,
    input  logic [7:0]     rd_data_i,
    output logic           wr_en_o,
    output logic [15:0]    wr_addr_o,
    output logic [7:0]     wr_data_o,
    output logic           busy_o,
    output logic           done_o,
    output logic [15:0]    src_o,
    output logic [15:0]    dst_o,
    output logic [15:0]    cnt_o
);

    seq_regs_t       r_d, r_q;
    logic [AW-1:0]   src_nx, dst_nx, cnt_nx, rd_addr;
    logic            last;
    logic [PH_W-1:0] phase;
    logic            step_end;
    logic            running;

    assign running = (r_q.st == ST_RUN);

    blkcopy_addr_step #(.PAT_BITS(PAT_BITS)) u_step (
        .mode_i    (r_q.mode),
        .src_i     (r_q.src),
        .dst_i     (r_q.dst),
        .cnt_i     (r_q.cnt),
        .rd_addr_o (rd_addr),
        .src_nx_o  (src_nx),
        .dst_nx_o  (dst_nx),
        .cnt_nx_o  (cnt_nx),
        .last_o    (last)
    );

    blkcopy_step_timer #(.COST_CONT(STEP_CONT), .COST_LAST(STEP_LAST)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (running),
        .cont_i  (r_q.cont),
        .phase_o (phase),
        .end_o   (step_end)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        rd_en_o   = 1'b0;
        wr_en_o   = 1'b0;
        rd_addr_o = rd_addr;
        wr_addr_o = r_q.dst;
        wr_data_o = rd_data_i;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_RUN;
                    r_d.mode = decode_mode(mode_i);
                    r_d.rep  = repeat_i;
                    r_d.cont = 1'b0;
                    r_d.src  = src_i;
                    r_d.dst  = dst_i;
                    r_d.cnt  = cnt_i;
                end
            end
            default: begin
                if (phase == '0) begin
                    rd_en_o  = 1'b1;
                    // continue/finish is decided on the count before it is decremented
                    r_d.cont = r_q.rep && (r_q.mode != MODE_WRAP) && !last;
                end
                if (phase == PH_W'(1)) begin
                    wr_en_o = 1'b1;
                    r_d.src = src_nx;
                    r_d.dst = dst_nx;
                    r_d.cnt = cnt_nx;
                end
                if (step_end && !r_q.cont) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, mode: MODE_UP, rep: 1'b0, cont: 1'b0,
                     done: 1'b0, src: '0, dst: '0, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = running;
    assign done_o = r_q.done;
    assign src_o  = r_q.src;
    assign dst_o  = r_q.dst;
    assign cnt_o  = r_q.cnt;

    AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(rd_en_o));  // R8
    AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);  // R9
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));  // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(r_q.mode) && $stable(r_q.rep)));  // R10
    AST_PAT_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && r_q.mode == MODE_PAT) |-> $stable(src_o));  // R4
    AST_WRAP_CNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && r_q.mode == MODE_WRAP) |-> $stable(cnt_o));  // R5

endmodule

// File: tb/blkcopy_seq_test.sv
module blkcopy_seq_test;

    localparam int CONT = 21;
    localparam int LAST = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    int errs = 0;
    int checks = 0;

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    // main instance
    logic        start_i = 1'b0, repeat_i = 1'b0;
    logic [2:0]  mode_i = 3'd0;
    logic [15:0] src_i = '0, dst_i = '0, cnt_i = '0;
    logic        rd_en, wr_en, busy, done;
    logic [15:0] rd_addr, wr_addr, src_o, dst_o, cnt_o;
    logic [7:0]  rdata = '0, wr_data;

    blkcopy_seq #(.STEP_CONT(CONT), .STEP_LAST(LAST)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .repeat_i(repeat_i), .src_i(src_i), .dst_i(dst_i), .cnt_i(cnt_i),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rdata),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .busy_o(busy), .done_o(done), .src_o(src_o), .dst_o(dst_o), .cnt_o(cnt_o));

    always @(posedge clk) if (rd_en) rdata <= mem_f(rd_addr);

    // short-step instance for the full 65536-element run
    logic        z_start = 1'b0;
    logic        z_rd_en, z_wr_en, z_busy, z_done;
    logic [15:0] z_rd_addr, z_wr_addr, z_src, z_dst, z_cnt;
    logic [7:0]  z_rdata = '0, z_wr_data;
    int          z_writes = 0;

    blkcopy_seq #(.STEP_CONT(2), .STEP_LAST(2)) uut_z (
        .clk(clk), .rst_n(rst_n), .start_i(z_start), .mode_i(3'd0),
        .repeat_i(1'b1), .src_i(16'h1234), .dst_i(16'h8000), .cnt_i(16'h0000),
        .rd_en_o(z_rd_en), .rd_addr_o(z_rd_addr), .rd_data_i(z_rdata),
        .wr_en_o(z_wr_en), .wr_addr_o(z_wr_addr), .wr_data_o(z_wr_data),
        .busy_o(z_busy), .done_o(z_done), .src_o(z_src), .dst_o(z_dst), .cnt_o(z_cnt));

    always @(posedge clk) begin
        if (z_rd_en) z_rdata <= mem_f(z_rd_addr);
        if (z_wr_en) z_writes <= z_writes + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_case(input int mode, input bit rep, input logic [15:0] s,
                            input logic [15:0] d, input logic [15:0] c, input bit poke);
        int m;
        int n, exp_cyc, busy_cyc, steps, ph, cost, bad;
        logic [15:0] ms, md, mc, ns, nd, nc, erd;
        longint bad_act, bad_exp;
        bit cont;
        string req;
        m = (mode > 4) ? 0 : mode;
        case (mode)
            0: req = "R1"; 1: req = "R2"; 2: req = "R3";
            3: req = "R4"; 4: req = "R5"; default: req = "R12";
        endcase
        n = (rep && m != 4) ? ((c == 16'h0) ? 65536 : int'(c)) : 1;
        exp_cyc = (n - 1) * CONT + LAST;
        ms = s; md = d; mc = c; ns = s; nd = d; nc = c; erd = s;
        busy_cyc = 0; steps = 0; ph = 0; cost = LAST; bad = 0; cont = 1'b0;
        bad_act = 0; bad_exp = 0;
        @(negedge clk);
        mode_i = 3'(mode); repeat_i = rep; src_i = s; dst_i = d; cnt_i = c; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (busy && busy_cyc < 5000) begin
            if (ph == 0) begin
                erd = (m == 3) ? {ms[15:3], md[2:0]} : ms;
                case (m)
                    1: begin ns = ms - 16'd1; nd = md - 16'd1; nc = mc - 16'd1; end
                    2: begin ns = ms - 16'd1; nd = md + 16'd1; nc = mc - 16'd1; end
                    3: begin ns = ms;         nd = md + 16'd1; nc = mc - 16'd1; end
                    4: begin ns = {ms[15:8], ms[7:0] + 8'd1};
                             nd = {md[15:8] + 8'd1, md[7:0]}; nc = mc; end
                    default: begin ns = ms + 16'd1; nd = md + 16'd1; nc = mc - 16'd1; end
                endcase
                cont = rep && (m != 4) && (nc != 16'h0);
                cost = cont ? CONT : LAST;
                if (!rd_en || wr_en || rd_addr != erd) begin
                    if (bad == 0) begin bad_act = rd_addr; bad_exp = erd; end
                    bad++;
                end
            end else if (ph == 1) begin
                if (!wr_en || rd_en || wr_addr != md || wr_data != mem_f(erd)) begin
                    if (bad == 0) begin bad_act = {wr_addr, wr_data}; bad_exp = {md, mem_f(erd)}; end
                    bad++;
                end
                ms = ns; md = nd; mc = nc; steps++;
            end else if (rd_en || wr_en) begin
                if (bad == 0) begin bad_act = {rd_en, wr_en}; bad_exp = 0; end
                bad++;
            end
            if (poke && busy_cyc == 3) begin
                start_i = 1'b1; mode_i = 3'(~mode); repeat_i = ~rep;
                src_i = ~s; dst_i = ~d; cnt_i = 16'h0005;
            end
            if (busy_cyc == 4) start_i = 1'b0;
            ph = (ph == cost - 1) ? 0 : ph + 1;
            busy_cyc++;
            @(negedge clk);
        end
        chk(bad == 0, poke ? "R10" : "R8", $sformatf("%s step strobes/addresses/data", req), bad_act, bad_exp);
        chk(steps == n, "R6", "element count", steps, n);
        chk(busy_cyc == exp_cyc, "R8", "busy length", busy_cyc, exp_cyc);
        chk(done == 1'b1, "R9", "done after busy", done, 1);
        chk(src_o == ms && dst_o == md && cnt_o == mc, poke ? "R10" : req,
            "final src/dst/cnt", {src_o, dst_o, cnt_o}, {ms, md, mc});
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R9", "done single clock", {done, busy}, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errs++; checks++;
        $display("FAIL R8 watchdog: cycles=190000 expected fewer");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [15:0] sa [2];
        logic [15:0] da [2];
        logic [15:0] ca [4];
        int zc;
        sa[0] = 16'h00FE; da[0] = 16'hFFFD;
        sa[1] = 16'h12FF; da[1] = 16'hFF07;
        ca[0] = 16'd1; ca[1] = 16'd2; ca[2] = 16'd5; ca[3] = 16'd0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !rd_en && !wr_en, "R11", "control after reset",
            {busy, done, rd_en, wr_en}, 0);
        chk(src_o == 0 && dst_o == 0 && cnt_o == 0, "R11", "result after reset",
            {src_o, dst_o, cnt_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int mode = 0; mode < 8; mode++)
            for (int rep = 0; rep < 2; rep++)
                for (int a = 0; a < 2; a++)
                    for (int k = 0; k < 4; k++)
                        if (!(rep == 1 && k == 3 && mode != 4))
                            run_case(mode, rep[0], sa[a], da[a], ca[k], 1'b0);
        run_case(0, 1'b1, 16'h4000, 16'h5000, 16'd3, 1'b1);  // R10
        run_case(3, 1'b1, 16'h2008, 16'h3006, 16'd9, 1'b1);  // R4 R10
        // R7: repeat with zero count on the short-step instance
        @(negedge clk); z_start = 1'b1;
        @(negedge clk); z_start = 1'b0;
        zc = 0;
        while (!z_done && zc < 140000) begin @(negedge clk); zc++; end
        chk(z_writes == 65536, "R7", "elements moved", z_writes, 65536);
        chk(z_cnt == 16'h0 && z_src == 16'h1234 && z_dst == 16'h8000, "R7",
            "final values", {z_src, z_dst, z_cnt}, {16'h1234, 16'h8000, 16'h0});
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule